// File: doc/BRIEF.md
# HDLC Channel Attach Selector

This block connects one serial HDLC controller to a single chosen place in a 32-channel E1 frame. It works one bit per clock. The frame is 256 bits long, and bit 0 is the first bit of channel 0. Three control inputs choose the place: an enable, a mode select and a 5-bit channel number.

- With the mode select at 1, the controller owns all eight bits of the chosen payload channel in every frame.
- With the mode select at 0, the controller owns the spare national bits. These are bits 4 to 8 of channel 0, counted from 1, and they are used only in frames that carry no alignment signal.

On the transmit side, the controller's bits replace the host's serial data in the owned positions. A request pulse asks for each transmit bit one cycle ahead. On the receive side, the owned bits are copied from the line data, which is tapped before any elastic buffering, and each copied bit is marked with a valid strobe.

A frame marker tells the block where frames begin. The marker is given in the cycle before bit 0, together with a flag that says whether the coming frame lacks the alignment signal. After the first marker, the block keeps counting by itself. At each frame boundary it loads the control inputs into a small state machine.

The states are:
- `ST_HUNT`: no frame position is known yet. This is the reset state.
- `ST_BYPASS`: the path is disconnected.
- `ST_SA`: the controller is attached to the spare bits.
- `ST_SLOT`: the controller is attached to a payload channel.

The transitions are:
- `ST_HUNT` leaves only on a frame marker.
- At every boundary, any state moves to `ST_BYPASS` when the enable is 0, to `ST_SA` when the enable is 1 and the select is 0, and to `ST_SLOT` when both are 1.
- Between boundaries, every state holds.

Top module: `hdlc_attach`

## Requirements
- R1: After reset and until the first frame marker, `line_tx_bit` equals `host_tx_bit`, and `tx_req` and `rx_valid` stay low.
- R2: `frm_start` high in a cycle makes the next cycle bit 0 of a frame. `frm_odd`, sampled in that same cycle, is 1 when that frame has no alignment signal. If no marker arrives, bit 255 is followed by bit 0 of a new frame, and the no-alignment flag inverts.
- R3: When the enable latched for a frame is 0, host data passes unchanged for the whole frame and no `rx_valid` strobe is issued for any of its bits.
- R4: In timeslot mode (`cfg_sel_ts`=1), the owned positions are frame bits 8*ch to 8*ch+7. Channel 0 is the first channel and channel 31 the last.
- R5: In spare-bit mode (`cfg_sel_ts`=0), the owned positions are frame bits 3 to 7, which are bits 4 to 8 of channel 0 counted from 1. They are owned only in frames flagged as having no alignment signal.
- R6: In an owned position, `line_tx_bit` equals `hdlc_tx_bit`. In every other position, it equals `host_tx_bit`.
- R7: `tx_req` is high in exactly the cycles that come just before an owned position. The controller's bit is taken from `hdlc_tx_bit` in the owned cycle itself.
- R8: `rx_valid` is high in exactly the cycles that follow an owned position. In those cycles, `rx_bit` holds the `line_rx_bit` value of the owned position.
- R9: `cfg_en`, `cfg_sel_ts` and `cfg_chan` are sampled only in the cycle before a frame's bit 0. A change in the middle of a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| frm_start | input | 1 | High in the cycle before a frame's bit 0 |
| frm_odd | input | 1 | With frm_start: coming frame has no alignment signal |
| cfg_en | input | 1 | Attach enable |
| cfg_sel_ts | input | 1 | 0 = spare bits, 1 = payload channel |
| cfg_chan | input | 5 | Payload channel number |
| host_tx_bit | input | 1 | Host serial transmit data |
| hdlc_tx_bit | input | 1 | Controller transmit bit |
| line_rx_bit | input | 1 | Line-side receive data |
| line_tx_bit | output | 1 | Transmit data toward the line |
| tx_req | output | 1 | Next cycle is an owned transmit position |
| rx_bit | output | 1 | Extracted receive bit |
| rx_valid | output | 1 | rx_bit is valid |

## Verification
The bench builds the block with its default parameters: 32 channels of 8 bits and the spare field starting at bit index 3. With these values, the 5-bit channel field reaches both end channels, 0 and 31. The frame wrap from bit 255 to bit 0 can then be exercised with and without a marker, so the request pulse that crosses the boundary and the strobe that trails it are both seen. The 5-bit spare field also lines up with a real E1 frame, which lets the bench show spare-bit ownership alternating between frames when the frame counter wraps on its own.

// File: rtl/hdlc_attach_pkg.sv
package hdlc_attach_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_BYPASS = 2'd1,
        ST_SA     = 2'd2,
        ST_SLOT   = 2'd3
    } att_state_e;
endpackage

// File: rtl/ha_frame_ctr.sv
module ha_frame_ctr #(
    parameter int NUM_CH  = 32,
    parameter int CH_BITS = 8,
    localparam int POS_W  = $clog2(NUM_CH) + $clog2(CH_BITS),
    localparam int LAST   = NUM_CH * CH_BITS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             synced,
    input  logic             frm_start,
    input  logic             frm_odd,
    output logic [POS_W-1:0] pos_q,
    output logic             odd_q,
    output logic [POS_W-1:0] pos_n,
    output logic             odd_n,
    output logic             bnd
);
    // A boundary is either an explicit marker or the wrap after the last bit.
    always_comb begin
        bnd   = frm_start | (synced & (pos_q == POS_W'(LAST)));
        pos_n = bnd ? '0 : pos_q + 1'b1;
        if (frm_start)
            odd_n = frm_odd;
        else if (bnd)
            odd_n = ~odd_q;
        else
            odd_n = odd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            odd_q <= 1'b0;
        end else begin
            pos_q <= pos_n;
            odd_q <= odd_n;
        end
    end
endmodule

// File: rtl/ha_ctrl_fsm.sv
module ha_ctrl_fsm
    import hdlc_attach_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bnd,
    input  logic            cfg_en,
    input  logic            cfg_sel_ts,
    input  logic [CH_W-1:0] cfg_chan,
    output att_state_e      state_q,
    output att_state_e      state_n,
    output logic [CH_W-1:0] chan_q,
    output logic [CH_W-1:0] chan_n,
    output logic            synced
);
    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            chan_q  <= '0;
        end else begin
            state_q <= state_n;
            chan_q  <= chan_n;
        end
    end

    // Next state: control inputs count only at a frame boundary.
    always_comb begin
        state_n = state_q;
        chan_n  = chan_q;
        if (bnd) begin
            chan_n = cfg_chan;
            unique case ({cfg_en, cfg_sel_ts})
                2'b10:   state_n = ST_SA;
                2'b11:   state_n = ST_SLOT;
                default: state_n = ST_BYPASS;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_HUNT: synced = 1'b0;
            default: synced = 1'b1;
        endcase
    end
endmodule

// File: rtl/ha_slot_match.sv
module ha_slot_match
    import hdlc_attach_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_BITS  = 8,
    parameter int SA_FIRST = 3,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int BIT_W   = $clog2(CH_BITS),
    localparam int POS_W   = CH_W + BIT_W
) (
    input  att_state_e       state,
    input  logic [POS_W-1:0] pos,
    input  logic             odd,
    input  logic [CH_W-1:0]  chan,
    output logic             hit
);
    logic [CH_BITS-1:0] sa_mask;
    logic [CH_W-1:0]    slot;
    logic [BIT_W-1:0]   bidx;

    for (genvar b = 0; b < CH_BITS; b++) begin : g_sa_mask
        assign sa_mask[b] = (b >= SA_FIRST);
    end

    assign slot = pos[POS_W-1:BIT_W];
    assign bidx = pos[BIT_W-1:0];

    always_comb begin
        unique case (state)
            ST_SLOT: hit = (slot == chan);
            ST_SA:   hit = odd & (slot == '0) & sa_mask[bidx];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/hdlc_attach.sv
module hdlc_attach
    import hdlc_attach_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_BITS  = 8,
    parameter int SA_FIRST = 3,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int POS_W   = CH_W + $clog2(CH_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_start,
    input  logic            frm_odd,
    input  logic            cfg_en,
    input  logic            cfg_sel_ts,
    input  logic [CH_W-1:0] cfg_chan,
    input  logic            host_tx_bit,
    input  logic            hdlc_tx_bit,
    input  logic            line_rx_bit,
    output logic            line_tx_bit,
    output logic            tx_req,
    output logic            rx_bit,
    output logic            rx_valid
);
    logic [POS_W-1:0] pos_q, pos_n;
    logic             odd_q, odd_n, bnd, synced;
    att_state_e       state_q, state_n;
    logic [CH_W-1:0]  chan_q, chan_n;
    logic             hit_n, hit_q;
    logic             rx_bit_q, rx_valid_q;

    ha_frame_ctr #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_ctr (
        .clk(clk), .rst_n(rst_n), .synced(synced),
        .frm_start(frm_start), .frm_odd(frm_odd),
        .pos_q(pos_q), .odd_q(odd_q), .pos_n(pos_n), .odd_n(odd_n), .bnd(bnd)
    );

    ha_ctrl_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bnd(bnd),
        .cfg_en(cfg_en), .cfg_sel_ts(cfg_sel_ts), .cfg_chan(cfg_chan),
        .state_q(state_q), .state_n(state_n),
        .chan_q(chan_q), .chan_n(chan_n), .synced(synced)
    );

    // The match looks one bit ahead so the request leads the owned bit.
    ha_slot_match #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .SA_FIRST(SA_FIRST)) u_match (
        .state(state_n), .pos(pos_n), .odd(odd_n), .chan(chan_n), .hit(hit_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q      <= 1'b0;
            rx_bit_q   <= 1'b0;
            rx_valid_q <= 1'b0;
        end else begin
            hit_q      <= hit_n;
            rx_bit_q   <= line_rx_bit;
            rx_valid_q <= hit_q;
        end
    end

    assign tx_req      = hit_n;
    assign line_tx_bit = hit_q ? hdlc_tx_bit : host_tx_bit;
    assign rx_bit      = rx_bit_q;
    assign rx_valid    = rx_valid_q;
endmodule

// File: rtl/hdlc_attach_chk.sv
module hdlc_attach_chk
    import hdlc_attach_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int CH_BITS = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_BITS),
    localparam int POS_W  = CH_W + BIT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_tx_bit,
    input logic             hdlc_tx_bit,
    input logic             line_rx_bit,
    input logic             line_tx_bit,
    input logic             tx_req,
    input logic             rx_bit,
    input logic             rx_valid,
    input att_state_e       state_q,
    input logic [POS_W-1:0] pos_q,
    input logic             odd_q,
    input logic [CH_W-1:0]  chan_q,
    input logic             bnd
);
    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT || state_q == ST_BYPASS) |-> line_tx_bit == host_tx_bit);

    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS && $past(state_q) == ST_BYPASS) |-> !rx_valid);

    assert_req_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> line_tx_bit == hdlc_tx_bit);

    assert_rx_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(tx_req, 2) && rx_bit == $past(line_rx_bit)));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> ($stable(state_q) && $stable(chan_q)));

    assert_sa_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SA && tx_req) |=> (odd_q && (pos_q >> BIT_W) == '0));
endmodule

bind hdlc_attach hdlc_attach_chk #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_tx_bit(host_tx_bit), .hdlc_tx_bit(hdlc_tx_bit), .line_rx_bit(line_rx_bit),
    .line_tx_bit(line_tx_bit), .tx_req(tx_req), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .state_q(state_q), .pos_q(pos_q), .odd_q(odd_q), .chan_q(chan_q), .bnd(bnd)
);

// File: tb/sim_hdlc_attach.sv
`timescale 1ns/1ps
module sim_hdlc_attach;
    localparam int FB = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0, frm_odd = 1'b0;
    logic       cfg_en = 1'b0, cfg_sel_ts = 1'b0;
    logic [4:0] cfg_chan = '0;
    logic       host_tx_bit = 1'b0, hdlc_tx_bit = 1'b0, line_rx_bit = 1'b0;
    wire        line_tx_bit, tx_req, rx_bit, rx_valid;

    int  checks = 0, errors = 0;
    bit  prev_hit = 1'b0;
    bit  prev_line = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_attach u0 (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_odd(frm_odd),
        .cfg_en(cfg_en), .cfg_sel_ts(cfg_sel_ts), .cfg_chan(cfg_chan),
        .host_tx_bit(host_tx_bit), .hdlc_tx_bit(hdlc_tx_bit), .line_rx_bit(line_rx_bit),
        .line_tx_bit(line_tx_bit), .tx_req(tx_req), .rx_bit(rx_bit), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(input bit en, input bit sel, input logic [4:0] ch,
                                   input bit odd, input int i);
        if (!en) return 1'b0;
        if (sel) return (i / 8) == int'(ch);
        return odd && (i >= 3) && (i < 8);
    endfunction

    task automatic randomize_data();
        host_tx_bit = 1'($urandom);
        line_rx_bit = 1'($urandom);
        hdlc_tx_bit = 1'($urandom);
    endtask

    // R1: no attachment before the first frame marker
    task automatic t_reset_hunt();
        int bad = 0;
        @(negedge clk);
        #1;
        check(!tx_req && !rx_valid && line_tx_bit == host_tx_bit, "R1", "reset state",
              {tx_req, rx_valid}, 0);
        rst_n = 1'b1;
        cfg_en = 1'b1; cfg_sel_ts = 1'b1; cfg_chan = 5'd0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            randomize_data();
            #1;
            if (tx_req || rx_valid || line_tx_bit != host_tx_bit) bad++;
        end
        check(bad == 0, "R1", "hunt mismatches", bad, 0);
    endtask

    task automatic t_prime(input bit en, input bit sel, input logic [4:0] ch, input bit odd);
        @(negedge clk);
        randomize_data();
        cfg_en = en; cfg_sel_ts = sel; cfg_chan = ch;
        frm_start = 1'b1; frm_odd = odd;
        #1;
        check(tx_req == exp_hit(en, sel, ch, odd, 0), "R7", "request before first bit",
              tx_req, exp_hit(en, sel, ch, odd, 0));
        check(line_tx_bit == host_tx_bit, "R1", "marker cycle passthrough",
              line_tx_bit, host_tx_bit);
        prev_hit = 1'b0;
    endtask

    // One frame of 256 bits; the next frame's control is driven from bit 100 on.
    task automatic t_frame(input string tag,
                           input bit en, input bit sel, input logic [4:0] ch, input bit odd,
                           input bit nen, input bit nsel, input logic [4:0] nch,
                           input bit use_start, input bit nodd_flag);
        int bad_tx = 0, bad_req = 0, bad_rv = 0, bad_rb = 0, n_req = 0, exp_req = 0;
        bit nodd = use_start ? nodd_flag : !odd;
        for (int i = 0; i < FB; i++) begin
            bit h, hn;
            @(negedge clk);
            randomize_data();
            if (i == 100) begin
                cfg_en = nen; cfg_sel_ts = nsel; cfg_chan = nch;
            end
            frm_start = use_start && (i == FB - 1);
            frm_odd   = (i == FB - 1) ? nodd_flag : 1'($urandom);
            #1;
            h  = exp_hit(en, sel, ch, odd, i);
            hn = (i == FB - 1) ? exp_hit(nen, nsel, nch, nodd, 0)
                               : exp_hit(en, sel, ch, odd, i + 1);
            if (line_tx_bit != (h ? hdlc_tx_bit : host_tx_bit)) bad_tx++;
            if (tx_req != hn) bad_req++;
            if (rx_valid != prev_hit) bad_rv++;
            if (prev_hit && rx_bit != prev_line) bad_rb++;
            if (i < FB - 1) begin
                n_req   += int'(tx_req);
                exp_req += int'(hn);
            end
            prev_hit  = h;
            prev_line = line_rx_bit;
        end
        check(bad_tx == 0, {tag, " R6"}, "transmit substitution mismatches", bad_tx, 0);
        check(bad_req == 0, {tag, " R7"}, "request timing mismatches", bad_req, 0);
        check(bad_rv == 0, {tag, " R8"}, "strobe timing mismatches", bad_rv, 0);
        check(bad_rb == 0, {tag, " R8"}, "extracted bit mismatches", bad_rb, 0);
        check(n_req == exp_req, tag, "owned positions in frame", n_req, exp_req);
    endtask

    initial begin
        t_reset_hunt();
        t_prime(1'b1, 1'b1, 5'd20, 1'b0);
        t_frame("R4 R9 ch20", 1, 1, 5'd20, 0, 1, 1, 5'd0,  1, 1);
        t_frame("R4 ch0",     1, 1, 5'd0,  1, 1, 1, 5'd31, 1, 0);
        t_frame("R4 ch31",    1, 1, 5'd31, 0, 1, 0, 5'd0,  1, 0);
        t_frame("R5 aligned", 1, 0, 5'd0,  0, 1, 0, 5'd0,  1, 1);
        t_frame("R5 spare",   1, 0, 5'd0,  1, 1, 0, 5'd0,  0, 0);
        t_frame("R2 wrap0",   1, 0, 5'd0,  0, 1, 0, 5'd0,  0, 0);
        t_frame("R2 wrap1",   1, 0, 5'd0,  1, 0, 1, 5'd9,  1, 0);
        t_frame("R3 off",     0, 1, 5'd9,  0, 1, 1, 5'd9,  1, 1);
        t_frame("R4 ch9",     1, 1, 5'd9,  1, 1, 1, 5'd9,  1, 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule